// File: doc/BRIEF.md
# Prioritized Nested Event Controller

This block arbitrates sixteen event levels for a processor core. Requests can come from dedicated request lines, from a software raise command that names a level, or from a software exception command that carries a 4-bit cause code. Each request is captured in a latch register. A mask register gates the maskable levels. The controller then picks the most urgent enabled event.

A pending-service register records every level whose handler has been entered and has not yet returned. A new event preempts only when it is strictly more urgent than every level already in service, so handlers nest. Level 0 is the most urgent and level 15 the least. Levels 0 to 3 are emulation, reset, non-maskable and exception; they cannot be masked. Level 4 is reserved. Level 5 is hardware error, level 6 is the core timer, and levels 7 to 15 are general purpose.

Each cycle the block shows the chosen level and a take pulse. The core uses these to fetch a vector. The core signals the end of a handler with a return strobe.

Top module: `prio_event_ctrl`

## Requirements
- R1: While reset is asserted, mask_o reads 0x000F (only levels 0 to 3 enabled), latch_o and pend_o read 0, and take_o is low.
- R2: A high on req_i[n] sets latch_o[n] at the next clock edge. The reserved level 4 never latches, whether the request comes from a line or from a raise.
- R3: A raise command (raise_vld_i with level n in raise_lvl_i) sets latch_o[n] at the next clock edge.
- R4: An exception command sets latch_o[3] at the next edge and loads its 4-bit code into cause_o, which holds that code until the next exception command.
- R5: A mask write loads mask_wdata_i into bits 15:4 of mask_o. Bits 3:0 always read 1.
- R6: take_o is high in the cycle when the lowest-numbered latched, enabled level is numerically lower than every set bit of pend_o, and take_lvl_o then gives that level. An equal level already in service blocks the take. Levels 0 to 3 count as enabled whatever the mask holds.
- R7: At the edge that ends a take cycle, the taken latch bit clears and the matching pend bit sets. A new request for the same level in that same cycle leaves the latch bit set.
- R8: A return strobe clears the lowest-numbered set bit of pend_o at the next edge. With pend_o at zero it changes nothing.
- R9: When a take and a return fall in the same cycle, the return clears the previous innermost level and the taken level is added. Both take effect at the same edge.
- R10: A latched level whose mask bit is 0 is not taken and stays latched. It is taken once its mask bit is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Per-level request lines |
| raise_vld_i | input | 1 | Software raise command strobe |
| raise_lvl_i | input | 4 | Level named by the raise command |
| excpt_vld_i | input | 1 | Software exception command strobe |
| excpt_cause_i | input | 4 | Cause code of the exception command |
| ret_i | input | 1 | Return-from-event strobe |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 16 | Mask register write data |
| take_o | output | 1 | An event is taken this cycle |
| take_lvl_o | output | 4 | Level being taken |
| cause_o | output | 4 | Last recorded exception cause code |
| mask_o | output | 16 | Mask register |
| latch_o | output | 16 | Latched-request register |
| pend_o | output | 16 | Pending-service register |

## Verification
Two kinds of cycle are hard. In the first, a take and a return fall in the same cycle. The bench sets this up by raising an exception while a general level is in service, so the exception is taken just as the return strobe clears the older level. The bench judges it by checking that pend_o holds only the exception bit afterwards. In the second, a take and a fresh request for the same level fall in the same cycle. The bench checks that the latch bit survives, and that the strict-priority rule then holds it back until the return.

// File: rtl/evt_pkg.sv
package evt_pkg;
   // fixed level assignments of the event map
   localparam int unsigned LVL_EMU    = 0;
   localparam int unsigned LVL_RESET  = 1;
   localparam int unsigned LVL_NMI    = 2;
   localparam int unsigned LVL_EXCPT  = 3;
   localparam int unsigned LVL_RSVD   = 4;
   localparam int unsigned LVL_HWERR  = 5;
   localparam int unsigned LVL_TIMER  = 6;
   localparam int unsigned LVL_GP_LO  = 7;
   localparam int unsigned NUM_UNMASK = 4;
endpackage

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
   parameter  int unsigned N  = 16,
   localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [LW-1:0] idx_o
);
   // lowest index wins: scan downward so the last hit is the smallest
   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = LW'(i);
      end
   end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
   parameter int unsigned N         = 16,
   parameter int unsigned NUM_FIXED = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] mask_o
);
   for (genvar b = 0; b < N; b++) begin : g_bit
      if (b < NUM_FIXED) begin : g_fixed
         logic wr_unused;
         assign wr_unused = wdata_i[b];
         assign mask_o[b] = 1'b1;
      end else begin : g_prog
         logic q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)   q <= 1'b0;
            else if (we_i) q <= wdata_i[b];
         end
         assign mask_o[b] = q;
      end
   end
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank #(
   parameter  int unsigned N       = 16,
   parameter  int unsigned EXC_LVL = 3,
   parameter  bit          HAS_RSV = 1'b1,
   parameter  int unsigned RSV_LVL = 4,
   localparam int unsigned LW      = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  req_i,
   input  logic          raise_vld_i,
   input  logic [LW-1:0] raise_lvl_i,
   input  logic          excpt_vld_i,
   input  logic          clr_vld_i,
   input  logic [LW-1:0] clr_idx_i,
   output logic [N-1:0]  latch_o
);
   for (genvar b = 0; b < N; b++) begin : g_lvl
      if (HAS_RSV && (b == RSV_LVL)) begin : g_rsv
         logic req_unused;
         assign req_unused = req_i[b];
         assign latch_o[b] = 1'b0;
      end else begin : g_live
         logic q, set, clr;
         assign set = req_i[b]
                    | (raise_vld_i && (raise_lvl_i == LW'(b)))
                    | (excpt_vld_i && (b == EXC_LVL));
         assign clr = clr_vld_i && (clr_idx_i == LW'(b));
         // a fresh set wins over the clear of the same edge
         always_ff @(posedge clk_i) begin
            if (!rst_ni) q <= 1'b0;
            else         q <= (q & ~clr) | set;
         end
         assign latch_o[b] = q;
      end
   end
endmodule

// File: rtl/evt_pend_track.sv
module evt_pend_track #(
   parameter  int unsigned N  = 16,
   localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          set_vld_i,
   input  logic [LW-1:0] set_idx_i,
   input  logic          ret_i,
   output logic [N-1:0]  pend_o,
   output logic          run_any_o,
   output logic [LW-1:0] run_idx_o
);
   logic [N-1:0] pend_q, set_vec, clr_vec;

   evt_prio_pick #(.N(N)) u_run_pick (
      .vec_i (pend_q),
      .any_o (run_any_o),
      .idx_o (run_idx_o)
   );

   always_comb begin
      for (int i = 0; i < N; i++) begin
         set_vec[i] = set_vld_i && (set_idx_i == LW'(i));
         clr_vec[i] = ret_i && run_any_o && (run_idx_o == LW'(i));
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/prio_event_ctrl.sv
module prio_event_ctrl #(
   parameter  int unsigned NUM_LVL   = 16,
   parameter  int unsigned NUM_FIXED = evt_pkg::NUM_UNMASK,
   parameter  int unsigned EXC_LVL   = evt_pkg::LVL_EXCPT,
   parameter  bit          HAS_RSV   = 1'b1,
   parameter  int unsigned RSV_LVL   = evt_pkg::LVL_RSVD,
   parameter  int unsigned CAUSE_W   = 4,
   localparam int unsigned LW        = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_LVL-1:0]  req_i,
   input  logic                raise_vld_i,
   input  logic [LW-1:0]       raise_lvl_i,
   input  logic                excpt_vld_i,
   input  logic [CAUSE_W-1:0]  excpt_cause_i,
   input  logic                ret_i,
   input  logic                mask_we_i,
   input  logic [NUM_LVL-1:0]  mask_wdata_i,
   output logic                take_o,
   output logic [LW-1:0]       take_lvl_o,
   output logic [CAUSE_W-1:0]  cause_o,
   output logic [NUM_LVL-1:0]  mask_o,
   output logic [NUM_LVL-1:0]  latch_o,
   output logic [NUM_LVL-1:0]  pend_o
);
   // elaboration-time parameter checks
   if (NUM_LVL < 2 || NUM_LVL > 64) begin : g_bad_lvl
      $error("NUM_LVL must lie in 2..64");
   end
   if (NUM_FIXED > NUM_LVL) begin : g_bad_fixed
      $error("NUM_FIXED exceeds NUM_LVL");
   end
   if (EXC_LVL >= NUM_LVL) begin : g_bad_exc
      $error("EXC_LVL out of range");
   end
   if (HAS_RSV && (RSV_LVL >= NUM_LVL || RSV_LVL == EXC_LVL)) begin : g_bad_rsv
      $error("RSV_LVL out of range or equal to EXC_LVL");
   end
   if (CAUSE_W < 1) begin : g_bad_cause
      $error("CAUSE_W must be at least 1");
   end

   logic [NUM_LVL-1:0] elig;
   logic               sel_any, run_any, take;
   logic [LW-1:0]      sel_idx, run_idx;
   logic [CAUSE_W-1:0] cause_q;

   evt_mask_reg #(.N(NUM_LVL), .NUM_FIXED(NUM_FIXED)) u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (mask_we_i),
      .wdata_i (mask_wdata_i),
      .mask_o  (mask_o)
   );

   evt_latch_bank #(
      .N(NUM_LVL), .EXC_LVL(EXC_LVL), .HAS_RSV(HAS_RSV), .RSV_LVL(RSV_LVL)
   ) u_latch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i),
      .raise_vld_i (raise_vld_i),
      .raise_lvl_i (raise_lvl_i),
      .excpt_vld_i (excpt_vld_i),
      .clr_vld_i   (take),
      .clr_idx_i   (sel_idx),
      .latch_o     (latch_o)
   );

   assign elig = latch_o & mask_o;

   evt_prio_pick #(.N(NUM_LVL)) u_sel_pick (
      .vec_i (elig),
      .any_o (sel_any),
      .idx_o (sel_idx)
   );

   evt_pend_track #(.N(NUM_LVL)) u_pend (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_vld_i (take),
      .set_idx_i (sel_idx),
      .ret_i     (ret_i),
      .pend_o    (pend_o),
      .run_any_o (run_any),
      .run_idx_o (run_idx)
   );

   // strict preemption: the candidate must beat the innermost active level
   assign take = sel_any && (!run_any || (sel_idx < run_idx));

   always_ff @(posedge clk_i) begin
      if (!rst_ni)          cause_q <= '0;
      else if (excpt_vld_i) cause_q <= excpt_cause_i;
   end

   assign take_o     = take;
   assign take_lvl_o = sel_idx;
   assign cause_o    = cause_q;
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk #(
   parameter  int unsigned NUM_LVL   = 16,
   parameter  int unsigned NUM_FIXED = 4,
   parameter  int unsigned EXC_LVL   = 3,
   localparam int unsigned LW        = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               excpt_vld_i,
   input logic               ret_i,
   input logic               take_o,
   input logic [LW-1:0]      take_lvl_o,
   input logic [NUM_LVL-1:0] mask_o,
   input logic [NUM_LVL-1:0] latch_o,
   input logic [NUM_LVL-1:0] pend_o
);
   logic [NUM_LVL-1:0] upto;
   always_comb begin
      for (int i = 0; i < NUM_LVL; i++) upto[i] = (i <= int'(take_lvl_o));
   end

   // R6
   take_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (latch_o[take_lvl_o] && ((pend_o & upto) == '0)));

   // R7
   take_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> pend_o[$past(take_lvl_o)]);

   // R8
   ret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && !take_o && (pend_o != '0)) |=>
         ($countones(pend_o) == $countones($past(pend_o)) - 1));

   // R4
   excpt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      excpt_vld_i |=> latch_o[EXC_LVL]);

   // R10
   masked_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && (int'(take_lvl_o) >= NUM_FIXED)) |-> mask_o[take_lvl_o]);
endmodule

bind prio_event_ctrl evt_ctrl_chk #(
   .NUM_LVL(NUM_LVL), .NUM_FIXED(NUM_FIXED), .EXC_LVL(EXC_LVL)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .excpt_vld_i (excpt_vld_i),
   .ret_i       (ret_i),
   .take_o      (take_o),
   .take_lvl_o  (take_lvl_o),
   .mask_o      (mask_o),
   .latch_o     (latch_o),
   .pend_o      (pend_o)
);

// File: tb/test_prio_event_ctrl.sv
module test_prio_event_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] req;
   logic        rv, ev, rt, mw;
   logic [3:0]  rl, ec;
   logic [15:0] md;
   logic        take;
   logic [3:0]  take_lvl, cause;
   logic [15:0] mask, latch, pend;

   int n_total = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   prio_event_ctrl i_prio_event_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req),
      .raise_vld_i(rv), .raise_lvl_i(rl),
      .excpt_vld_i(ev), .excpt_cause_i(ec),
      .ret_i(rt), .mask_we_i(mw), .mask_wdata_i(md),
      .take_o(take), .take_lvl_o(take_lvl), .cause_o(cause),
      .mask_o(mask), .latch_o(latch), .pend_o(pend)
   );

   typedef struct packed {
      logic [15:0] rq; logic rv; logic [3:0] rl; logic ev; logic [3:0] ec;
      logic rt; logic mw; logic [15:0] md;
      logic [15:0] exl; logic [15:0] exp; logic ext; logic [3:0] exlv;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b0,1'b1,16'hFFF0, 16'h0000,16'h0000,1'b0,4'd0},  // R5 write
      '{16'h0400,1'b0,4'd0, 1'b0,4'd0,1'b0,1'b0,16'h0000, 16'h0400,16'h0000,1'b1,4'd10}, // R2 R6
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b0,1'b0,16'h0000, 16'h0000,16'h0400,1'b0,4'd0},  // R7
      '{16'h0000,1'b1,4'd12,1'b0,4'd0,1'b0,1'b0,16'h0000, 16'h1000,16'h0400,1'b0,4'd0},  // R3 R6
      '{16'h0080,1'b0,4'd0, 1'b0,4'd0,1'b0,1'b0,16'h0000, 16'h1080,16'h0400,1'b1,4'd7},  // R6 nest
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b0,1'b0,16'h0000, 16'h1000,16'h0480,1'b0,4'd0},  // R7
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b1,1'b0,16'h0000, 16'h1000,16'h0400,1'b0,4'd0},  // R8
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b1,1'b0,16'h0000, 16'h1000,16'h0000,1'b1,4'd12}, // R8 R6
      '{16'h0000,1'b0,4'd0, 1'b1,4'd9,1'b0,1'b0,16'h0000, 16'h0008,16'h1000,1'b1,4'd3},  // R4 R7
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b1,1'b0,16'h0000, 16'h0000,16'h0008,1'b0,4'd0},  // R9
      '{16'h0010,1'b1,4'd4, 1'b0,4'd0,1'b0,1'b0,16'h0000, 16'h0000,16'h0008,1'b0,4'd0},  // R2 reserved
      '{16'h0000,1'b0,4'd0, 1'b0,4'd0,1'b1,1'b0,16'h0000, 16'h0000,16'h0000,1'b0,4'd0}   // R8
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R5";  1: return "R2";  2: return "R7";  3: return "R3";
         4: return "R6";  5: return "R7";  6: return "R8";  7: return "R8";
         8: return "R4";  9: return "R9";  10: return "R2"; default: return "R8";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] q, input logic v, input logic [3:0] l,
                       input logic e, input logic [3:0] c, input logic r,
                       input logic w, input logic [15:0] d);
      @(negedge clk);
      req = q; rv = v; rl = l; ev = e; ec = c; rt = r; mw = w; md = d;
      @(posedge clk);
      #1;
      req = '0; rv = 0; rl = '0; ev = 0; ec = '0; rt = 0; mw = 0; md = '0;
   endtask

   task automatic idle();
      step(16'h0, 0, 4'd0, 0, 4'd0, 0, 0, 16'h0);
   endtask

   task automatic state(input string tag, input logic [15:0] l, input logic [15:0] p,
                        input logic t, input logic [3:0] lv);
      chk({tag, " latch"}, 32'(latch), 32'(l));
      chk({tag, " pend"},  32'(pend),  32'(p));
      chk({tag, " take"},  32'(take),  32'(t));
      if (t) chk({tag, " level"}, 32'(take_lvl), 32'(lv));
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      rst_n = 0; req = '0; rv = 0; rl = '0; ev = 0; ec = '0; rt = 0; mw = 0; md = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", 32'(mask), 32'h000F);
      state("R1", 16'h0, 16'h0, 1'b0, 4'd0);
      rst_n = 1;

      for (int i = 0; i < 12; i++) begin
         step(TBL[i].rq, TBL[i].rv, TBL[i].rl, TBL[i].ev, TBL[i].ec,
              TBL[i].rt, TBL[i].mw, TBL[i].md);
         state($sformatf("%s entry %0d", tag_of(i), i),
               TBL[i].exl, TBL[i].exp, TBL[i].ext, TBL[i].exlv);
      end
      chk("R4 cause", 32'(cause), 32'd9);
      chk("R5 fixed bits read one", 32'(mask), 32'hFFFF);

      // R5 clearing the mask leaves levels 0..3 enabled
      step(16'h0, 0, 4'd0, 0, 4'd0, 0, 1, 16'h0000);
      chk("R5 mask clear", 32'(mask), 32'h000F);

      // R10 masked request waits
      step(16'h0200, 0, 4'd0, 0, 4'd0, 0, 0, 16'h0);
      state("R10 masked", 16'h0200, 16'h0, 1'b0, 4'd0);
      idle(); idle();
      state("R10 held", 16'h0200, 16'h0, 1'b0, 4'd0);

      // R6 non-maskable level taken with mask cleared
      step(16'h0004, 0, 4'd0, 0, 4'd0, 0, 0, 16'h0);
      state("R6 nmi", 16'h0204, 16'h0, 1'b1, 4'd2);
      idle();
      state("R7 nmi enter", 16'h0200, 16'h0004, 1'b0, 4'd0);
      step(16'h0, 0, 4'd0, 0, 4'd0, 1, 0, 16'h0);
      state("R10 still masked", 16'h0200, 16'h0, 1'b0, 4'd0);

      // R10 enabling the mask releases it
      step(16'h0, 0, 4'd0, 0, 4'd0, 0, 1, 16'h0200);
      state("R10 unmasked", 16'h0200, 16'h0, 1'b1, 4'd9);
      idle();
      state("R7 enter 9", 16'h0, 16'h0200, 1'b0, 4'd0);

      // R6 equal level in service blocks the take
      step(16'h0, 1, 4'd9, 0, 4'd0, 0, 0, 16'h0);
      state("R6 equal blocked", 16'h0200, 16'h0200, 1'b0, 4'd0);
      step(16'h0, 0, 4'd0, 0, 4'd0, 1, 0, 16'h0);
      state("R6 after return", 16'h0200, 16'h0, 1'b1, 4'd9);
      idle();
      state("R7 re-enter 9", 16'h0, 16'h0200, 1'b0, 4'd0);
      step(16'h0, 0, 4'd0, 0, 4'd0, 1, 0, 16'h0);
      state("R8 pop 9", 16'h0, 16'h0, 1'b0, 4'd0);

      // R8 return with nothing pending
      step(16'h0, 0, 4'd0, 0, 4'd0, 1, 0, 16'h0);
      state("R8 empty return", 16'h0, 16'h0, 1'b0, 4'd0);

      // R7 re-request in the take cycle keeps the latch
      step(16'h0, 0, 4'd0, 0, 4'd0, 0, 1, 16'hFFFF);
      step(16'h0800, 0, 4'd0, 0, 4'd0, 0, 0, 16'h0);
      state("R7 first", 16'h0800, 16'h0, 1'b1, 4'd11);
      step(16'h0800, 0, 4'd0, 0, 4'd0, 0, 0, 16'h0);
      state("R7 relatch", 16'h0800, 16'h0800, 1'b0, 4'd0);
      step(16'h0, 0, 4'd0, 0, 4'd0, 1, 0, 16'h0);
      state("R7 second", 16'h0800, 16'h0, 1'b1, 4'd11);
      idle();
      state("R7 second enter", 16'h0, 16'h0800, 1'b0, 4'd0);

      // R4 new cause overwrites
      step(16'h0, 0, 4'd0, 1, 4'd13, 0, 0, 16'h0);
      chk("R4 cause update", 32'(cause), 32'd13);
      state("R4 excpt over 11", 16'h0008, 16'h0800, 1'b1, 4'd3);

      summary();
   end
endmodule